// File: doc/BRIEF.md
# Register File Vulnerability Accumulator

This monitor sits beside a small register file and measures how long its contents are exposed to soft errors, counted in bit-cycles. It watches two read ports and one write port. Each port gives a valid flag and a register index, and the monitor also takes a shared cycle timestamp. For every register it keeps the timestamp of the most recent access. When a new access arrives, the interval since that access is judged. An interval that ends in a read was holding a value that was later used, so its length times the register width is credited. An interval that ends in a write held a value that was thrown away, so it is discarded.

The block keeps a running total for the whole register file, plus one total per register that can be read back through a one-cycle query port. Both kinds of total saturate and carry a sticky overflow flag. The whole-file total is a plain unsigned output, so an adder can sum it with the outputs of similar monitors on other structures. At the end of a run, a drain pulse closes every open interval as not vulnerable.

Top module: `rfv_acc`

## Requirements
- R1: Reset clears the total, the total overflow flag, every per-register total and every per-register flag, and it drops the query response valid. While reset is held, each register's last-access time is loaded from `cyc_ts`. A read after reset is therefore credited from the reset timestamp.
- R2: A valid read of register r at timestamp T adds (T - last_r) * REG_W to the total and to r's own total, with the subtraction taken modulo 2^TS_W. It then sets last_r to T. The total reflects the read on the cycle after the edge at which the read is sampled.
- R3: A valid write sets last_r to T and adds nothing, so the interval it closes is discarded. A cycle with no valid read leaves the total unchanged.
- R4: After a write, each of several later reads of the same register is credited with the time since the previous access to that register, read or write.
- R5: Within one cycle the events are applied in this order: read port 0, then read port 1, then the write. A second read of the same register in the same cycle adds zero. A read and a write to the same register in the same cycle credit the read.
- R6: A drain pulse sets every register's last-access time to T and leaves all totals unchanged. A read on the drain cycle is still credited, and a later read counts only from the drain timestamp.
- R7: If an addition would exceed 2^ACC_W - 1, the total stays at all ones and its sticky overflow flag is set. The same rule applies to each per-register total and its own flag. A flag stays set until reset.
- R8: A query of register index q asserts `qry_rsp_vld` on the next cycle only. The response carries r_q's total and flag as they stood before the events of the query cycle. While no total has saturated, the per-register totals sum to the whole-file total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_ts | input | TS_W | Current cycle timestamp |
| rd0_vld | input | 1 | Read port 0 event valid |
| rd0_idx | input | IDX_W | Read port 0 register index |
| rd1_vld | input | 1 | Read port 1 event valid |
| rd1_idx | input | IDX_W | Read port 1 register index |
| wr_vld | input | 1 | Write port event valid |
| wr_idx | input | IDX_W | Write port register index |
| drain | input | 1 | End-of-run pulse that closes all open intervals |
| qry_vld | input | 1 | Per-register total query |
| qry_idx | input | IDX_W | Register index to query |
| total | output | ACC_W | Whole-file vulnerable bit-cycles |
| total_ovf | output | 1 | Sticky saturation flag of the total |
| qry_rsp_vld | output | 1 | Query response valid |
| qry_total | output | ACC_W | Queried register's total |
| qry_ovf | output | 1 | Queried register's sticky saturation flag |

## Verification
The bench builds the block with four registers, a width of six bits, an 8-bit timestamp and a 16-bit accumulator. A width of six is not a power of two, so the multiplying variant of the scaler is used. The narrow timestamp brings intervals that wrap modulo 256 within reach. The narrow accumulator lets repeated long read intervals on two ports drive both the whole-file total and single per-register totals into saturation within a few thousand cycles. Against these parameters, a reference model in the bench predicts the total, the flags and each query response every cycle. It covers same-cycle port collisions, overwrites, drain and query timing.

// File: rtl/rfv_pkg.sv
package rfv_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rfv_scale.sv
// Converts an interval length in cycles to bit-cycles for one register.
module rfv_scale #(
   parameter int unsigned TS_W  = 32,
   parameter int unsigned REG_W = 32,
   parameter int unsigned OUT_W = 37
) (
   input  logic [TS_W-1:0]  span,
   output logic [OUT_W-1:0] bitcyc
);
   localparam int unsigned SH = $clog2(REG_W);

   generate
      if (rfv_pkg::is_pow2(REG_W)) begin : g_shift
         assign bitcyc = OUT_W'(span) << SH;
      end else begin : g_mult
         assign bitcyc = OUT_W'(span) * OUT_W'(REG_W);
      end
   endgenerate
endmodule

// File: rtl/rfv_sat_acc.sv
// Saturating accumulator with sticky overflow.
module rfv_sat_acc #(
   parameter int unsigned ACC_W = 64,
   parameter int unsigned INC_W = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   output logic [ACC_W-1:0] acc,
   output logic             ovf
);
   logic [ACC_W:0] sum;

   assign sum = {1'b0, acc} + (ACC_W+1)'(inc);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0;
         ovf <= 1'b0;
      end else if (sum[ACC_W]) begin
         acc <= '1;
         ovf <= 1'b1;
      end else begin
         acc <= sum[ACC_W-1:0];
      end
   end
endmodule

// File: rtl/rfv_slot.sv
// Per-register state: last access time and credited bit-cycles.
module rfv_slot #(
   parameter int unsigned TS_W  = 32,
   parameter int unsigned ACC_W = 64,
   parameter int unsigned INC_W = 37
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  cyc_ts,
   input  logic             touch,
   input  logic [INC_W-1:0] credit,
   output logic [TS_W-1:0]  last_ts,
   output logic [ACC_W-1:0] acc,
   output logic             ovf
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_ts <= cyc_ts;
      end else if (touch) begin
         last_ts <= cyc_ts;
      end
   end

   rfv_sat_acc #(
      .ACC_W(ACC_W),
      .INC_W(INC_W)
   ) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (credit),
      .acc  (acc),
      .ovf  (ovf)
   );
endmodule

// File: rtl/rfv_query.sv
// Registered readout of one per-register total.
module rfv_query #(
   parameter int unsigned NREGS = 16,
   parameter int unsigned ACC_W = 64,
   parameter int unsigned IDX_W = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        qry_vld,
   input  logic [IDX_W-1:0]            qry_idx,
   input  logic [NREGS-1:0][ACC_W-1:0] acc_all,
   input  logic [NREGS-1:0]            ovf_all,
   output logic                        rsp_vld,
   output logic [ACC_W-1:0]            rsp_total,
   output logic                        rsp_ovf
);
   logic             in_range;
   logic [ACC_W-1:0] sel_total;
   logic             sel_ovf;

   generate
      if (NREGS == (1 << IDX_W)) begin : g_full
         assign in_range = 1'b1;
      end else begin : g_part
         assign in_range = (32'(qry_idx) < NREGS);
      end
   endgenerate

   always_comb begin
      sel_total = '0;
      sel_ovf   = 1'b0;
      for (int i = 0; i < NREGS; i++) begin
         if (in_range && (qry_idx == IDX_W'(i))) begin
            sel_total = acc_all[i];
            sel_ovf   = ovf_all[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_total <= '0;
         rsp_ovf   <= 1'b0;
      end else begin
         rsp_vld <= qry_vld;
         if (qry_vld) begin
            rsp_total <= sel_total;
            rsp_ovf   <= sel_ovf;
         end
      end
   end
endmodule

// File: rtl/rfv_acc.sv
// Register file vulnerability accumulator (top).
module rfv_acc #(
   parameter int unsigned NREGS = 16,
   parameter int unsigned REG_W = 32,
   parameter int unsigned TS_W  = 32,
   parameter int unsigned ACC_W = 64,
   localparam int unsigned IDX_W = rfv_pkg::idx_width(NREGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  cyc_ts,
   input  logic             rd0_vld,
   input  logic [IDX_W-1:0] rd0_idx,
   input  logic             rd1_vld,
   input  logic [IDX_W-1:0] rd1_idx,
   input  logic             wr_vld,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             drain,
   input  logic             qry_vld,
   input  logic [IDX_W-1:0] qry_idx,
   output logic [ACC_W-1:0] total,
   output logic             total_ovf,
   output logic             qry_rsp_vld,
   output logic [ACC_W-1:0] qry_total,
   output logic             qry_ovf
);
   localparam int unsigned INC_W = TS_W + $clog2(REG_W);

   generate
      if (NREGS < 2) begin : g_err_nregs
         $error("rfv_acc: NREGS must be at least 2");
      end
      if (REG_W < 1) begin : g_err_regw
         $error("rfv_acc: REG_W must be at least 1");
      end
      if (ACC_W <= INC_W) begin : g_err_accw
         $error("rfv_acc: ACC_W must exceed TS_W + clog2(REG_W)");
      end
   endgenerate

   logic [NREGS-1:0][TS_W-1:0]  last_all;
   logic [NREGS-1:0][ACC_W-1:0] acc_all;
   logic [NREGS-1:0]            ovf_all;

   logic ok0, ok1, okw;
   logic hit0, hit1, hitw;

   generate
      if (NREGS == (1 << IDX_W)) begin : g_idx_full
         assign ok0 = 1'b1;
         assign ok1 = 1'b1;
         assign okw = 1'b1;
      end else begin : g_idx_part
         assign ok0 = (32'(rd0_idx) < NREGS);
         assign ok1 = (32'(rd1_idx) < NREGS);
         assign okw = (32'(wr_idx) < NREGS);
      end
   endgenerate

   assign hit0 = rd0_vld && ok0;
   assign hit1 = rd1_vld && ok1;
   assign hitw = wr_vld && okw;

   // Last-access time seen by each read port.
   logic [TS_W-1:0] prev0, prev1;

   always_comb begin
      prev0 = '0;
      prev1 = '0;
      for (int i = 0; i < NREGS; i++) begin
         if (rd0_idx == IDX_W'(i)) prev0 = last_all[i];
         if (rd1_idx == IDX_W'(i)) prev1 = last_all[i];
      end
   end

   // Port 0 first; port 1 on the same register sees an interval of zero.
   logic            same_rd;
   logic [TS_W-1:0] span0, span1;

   assign same_rd = hit0 && (rd0_idx == rd1_idx);
   assign span0   = hit0 ? (cyc_ts - prev0) : '0;
   assign span1   = (hit1 && !same_rd) ? (cyc_ts - prev1) : '0;

   logic [INC_W-1:0] inc0, inc1;

   rfv_scale #(.TS_W(TS_W), .REG_W(REG_W), .OUT_W(INC_W)) u_scale0 (
      .span  (span0),
      .bitcyc(inc0)
   );

   rfv_scale #(.TS_W(TS_W), .REG_W(REG_W), .OUT_W(INC_W)) u_scale1 (
      .span  (span1),
      .bitcyc(inc1)
   );

   logic [INC_W:0] inc_sum;
   assign inc_sum = {1'b0, inc0} + {1'b0, inc1};

   rfv_sat_acc #(.ACC_W(ACC_W), .INC_W(INC_W+1)) u_total (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (inc_sum),
      .acc  (total),
      .ovf  (total_ovf)
   );

   generate
      for (genvar g = 0; g < NREGS; g++) begin : g_slot
         logic             sel0, sel1, selw;
         logic             touch;
         logic [INC_W-1:0] credit;

         assign sel0   = hit0 && (rd0_idx == IDX_W'(g));
         assign sel1   = hit1 && (rd1_idx == IDX_W'(g));
         assign selw   = hitw && (wr_idx == IDX_W'(g));
         assign touch  = sel0 || sel1 || selw || drain;
         assign credit = (sel0 ? inc0 : '0) | (sel1 ? inc1 : '0);

         rfv_slot #(.TS_W(TS_W), .ACC_W(ACC_W), .INC_W(INC_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .cyc_ts (cyc_ts),
            .touch  (touch),
            .credit (credit),
            .last_ts(last_all[g]),
            .acc    (acc_all[g]),
            .ovf    (ovf_all[g])
         );
      end
   endgenerate

   rfv_query #(.NREGS(NREGS), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_query (
      .clk      (clk),
      .rst_n    (rst_n),
      .qry_vld  (qry_vld),
      .qry_idx  (qry_idx),
      .acc_all  (acc_all),
      .ovf_all  (ovf_all),
      .rsp_vld  (qry_rsp_vld),
      .rsp_total(qry_total),
      .rsp_ovf  (qry_ovf)
   );
endmodule

// File: rtl/rfv_acc_chk.sv
module rfv_acc_chk #(
   parameter int unsigned ACC_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd0_vld,
   input logic             rd1_vld,
   input logic             qry_vld,
   input logic [ACC_W-1:0] total,
   input logic             total_ovf,
   input logic             qry_rsp_vld
);
   p_total_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (total >= $past(total)));

   p_no_read_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd0_vld && !rd1_vld) |=> $stable(total));

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      total_ovf |=> total_ovf);

   p_ovf_saturated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      total_ovf |-> (total == {ACC_W{1'b1}}));

   p_rsp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      qry_vld |=> qry_rsp_vld);

   p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !qry_vld |=> !qry_rsp_vld);
endmodule

bind rfv_acc rfv_acc_chk #(.ACC_W(ACC_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd0_vld    (rd0_vld),
   .rd1_vld    (rd1_vld),
   .qry_vld    (qry_vld),
   .total      (total),
   .total_ovf  (total_ovf),
   .qry_rsp_vld(qry_rsp_vld)
);

// File: tb/rfv_acc_bench.sv
module rfv_acc_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 4;
   localparam int RW = 6;
   localparam int TW = 8;
   localparam int AW = 16;
   localparam int IW = 2;
   localparam int WATCHDOG = 200000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [TW-1:0] cyc_ts = '0;
   logic          rd0_vld = 1'b0, rd1_vld = 1'b0, wr_vld = 1'b0;
   logic [IW-1:0] rd0_idx = '0, rd1_idx = '0, wr_idx = '0, qry_idx = '0;
   logic          drain = 1'b0, qry_vld = 1'b0;
   logic [AW-1:0] total, qry_total;
   logic          total_ovf, qry_rsp_vld, qry_ovf;

   always #(CLK_PERIOD/2) clk = ~clk;

   rfv_acc #(.NREGS(NR), .REG_W(RW), .TS_W(TW), .ACC_W(AW)) u_rfv_acc (
      .clk(clk), .rst_n(rst_n), .cyc_ts(cyc_ts),
      .rd0_vld(rd0_vld), .rd0_idx(rd0_idx),
      .rd1_vld(rd1_vld), .rd1_idx(rd1_idx),
      .wr_vld(wr_vld), .wr_idx(wr_idx),
      .drain(drain), .qry_vld(qry_vld), .qry_idx(qry_idx),
      .total(total), .total_ovf(total_ovf),
      .qry_rsp_vld(qry_rsp_vld), .qry_total(qry_total), .qry_ovf(qry_ovf)
   );

   typedef struct {
      string         tag;
      logic [AW-1:0] tot;
      logic          tov;
      logic          rv;
      logic [AW-1:0] qt;
      logic          qo;
   } item_t;

   item_t q[$];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state.
   logic [TW-1:0] now;
   logic [TW-1:0] m_last [NR];
   logic [AW-1:0] m_acc  [NR];
   logic          m_ovf  [NR];
   logic [AW-1:0] m_tot;
   logic          m_tov;

   task automatic chk(input string tag, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic sat_add(inout logic [AW-1:0] a, inout logic f, input int inc);
      logic [AW:0] s;
      s = {1'b0, a} + (AW+1)'(inc);
      if (s[AW]) begin
         a = '1;
         f = 1'b1;
      end else begin
         a = s[AW-1:0];
      end
   endtask

   task automatic model_read(input int r);
      logic [TW-1:0] d;
      int inc;
      d   = now - m_last[r];
      inc = int'(d) * RW;
      sat_add(m_acc[r], m_ovf[r], inc);
      sat_add(m_tot, m_tov, inc);
      m_last[r] = now;
   endtask

   task automatic step(input string tag, input bit r0v, input int r0i,
                       input bit r1v, input int r1i, input bit wv, input int wi,
                       input bit dr, input bit qv, input int qi);
      item_t it;
      cyc_ts  = now;
      rd0_vld = r0v; rd0_idx = IW'(r0i);
      rd1_vld = r1v; rd1_idx = IW'(r1i);
      wr_vld  = wv;  wr_idx  = IW'(wi);
      drain   = dr;
      qry_vld = qv;  qry_idx = IW'(qi);
      it.tag = tag;
      it.rv  = qv;
      it.qt  = m_acc[qi];
      it.qo  = m_ovf[qi];
      if (r0v) model_read(r0i);
      if (r1v) model_read(r1i);
      if (wv) m_last[wi] = now;
      if (dr) for (int i = 0; i < NR; i++) m_last[i] = now;
      it.tot = m_tot;
      it.tov = m_tov;
      q.push_back(it);
      @(negedge clk);
      now = now + 1'b1;
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic rd(input string tag, input int r);
      step(tag, 1, r, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(input string tag, input int r);
      step(tag, 0, 0, 0, 0, 1, r, 0, 0, 0);
   endtask

   task automatic ask(input string tag, input int r);
      step(tag, 0, 0, 0, 0, 0, 0, 0, 1, r);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Monitor: compares each cycle's results against the scoreboard.
   initial begin
      item_t it;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            it = q.pop_front();
            chk(it.tag, "total", total, it.tot);
            chk(it.tag, "total_ovf", AW'(total_ovf), AW'(it.tov));
            chk(it.tag, "qry_rsp_vld", AW'(qry_rsp_vld), AW'(it.rv));
            if (it.rv) begin
               chk(it.tag, "qry_total", qry_total, it.qt);
               chk(it.tag, "qry_ovf", AW'(qry_ovf), AW'(it.qo));
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
   end

   initial begin
      now = 8'd7;
      cyc_ts = now;
      for (int i = 0; i < NR; i++) begin
         m_last[i] = now;
         m_acc[i]  = '0;
         m_ovf[i]  = 1'b0;
      end
      m_tot = '0;
      m_tov = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state before any event.
      chk("R1", "total", total, '0);
      chk("R1", "total_ovf", AW'(total_ovf), '0);
      chk("R1", "qry_rsp_vld", AW'(qry_rsp_vld), '0);
      now = 8'd8;
      // R1: initial interval counted from the reset timestamp (1 * 6).
      rd("R1", 2);
      // R2/R3: write, idle, read.
      wr("R3", 1);
      idle("R3", 5);
      rd("R2", 1);
      // R4: write then several reads.
      wr("R4", 3);
      idle("R4", 2);
      rd("R4", 3);
      idle("R4", 3);
      rd("R4", 3);
      rd("R4", 3);
      // R3: overwrite discards the interval.
      wr("R3", 0);
      idle("R3", 10);
      wr("R3", 0);
      idle("R3", 1);
      rd("R3", 0);
      // R5: both ports same register, then read+write same register.
      idle("R5", 4);
      step("R5", 1, 1, 1, 1, 0, 0, 0, 0, 0);
      idle("R5", 3);
      step("R5", 1, 2, 0, 0, 1, 2, 0, 0, 0);
      idle("R5", 2);
      step("R5", 1, 0, 1, 3, 1, 3, 0, 0, 0);
      idle("R5", 2);
      rd("R5", 3);
      // R6: drain with a read in the same cycle, then later reads.
      idle("R6", 20);
      step("R6", 1, 2, 0, 0, 0, 0, 1, 0, 0);
      idle("R6", 3);
      rd("R6", 1);
      step("R6", 0, 0, 1, 0, 0, 0, 0, 0, 0);
      // R8: queries, including one on a cycle that reads the same register.
      for (int r = 0; r < NR; r++) ask("R8", r);
      idle("R8", 4);
      step("R8", 1, 2, 0, 0, 0, 0, 0, 1, 2);
      ask("R8", 2);
      // R2: interval wrapping modulo 2^TS_W.
      wr("R2", 3);
      idle("R2", 249);
      rd("R2", 3);
      // R7: drive total and per-register totals into saturation.
      for (int k = 0; k < 48; k++) begin
         idle("R7", 249);
         step("R7", 1, 0, 1, 1, 0, 0, 0, 0, 0);
      end
      for (int r = 0; r < NR; r++) ask("R7", r);
      rd("R7", 2);
      ask("R7", 0);
      idle("R7", 2);
      step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 0);
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule